// File: doc/BRIEF.md
# Packet Timestamp Capture Memory

This block sits beside a network port's physical layer and records when packets cross it. It holds a local copy of the lower 64 bits of the chip's source time, with one cycle of register delay. From that copy it cuts a 40-bit timestamp: 32 bits of nanoseconds and 8 bits of sub-nanosecond fraction. On events it writes the stamp into a small indexed memory. The memory is organised as a number of logical ports, each with a fixed number of timestamp slots.

Every receive event is stamped. The stamp goes into the lowest-numbered free slot of its port. A transmit event is stamped only when its request flag is raised. It names the slot it wants and is refused if that slot still holds an unread stamp. When a stamp is lost because no slot is free, or because the named slot is occupied, the port's sticky overflow flag is set.

Software reads each slot through two 32-bit words: a low word and a high word. The high word also carries the slot's valid bit and its port's overflow flag. Software frees a slot by writing zero to it.

Top module: `ts_capture_mem`

## Requirements
- R1: `local_time_o` equals the value `src_time_i` had in the previous clock cycle. A captured stamp is bits [63:24] of `local_time_o` in the cycle of the event: bits [55:24] become the slot's low word and bits [63:56] the slot's high stamp byte.
- R2: A receive event (`rx_evt_i`) stores the stamp in the lowest-numbered slot of `rx_port_i` whose valid bit is clear, and sets that slot's valid bit.
- R3: A receive event on a port whose slots are all valid stores nothing, leaves every slot unchanged and sets that port's bit in `ovf_o`. The bit stays set until it is cleared as stated in R8.
- R4: A transmit event with `tx_req_i` low stores nothing and sets no overflow.
- R5: A transmit event with `tx_req_i` high, naming a slot (`tx_port_i`, `tx_idx_i`) whose valid bit is clear, stores the stamp in that slot and sets its valid bit.
- R6: A requested transmit event naming a valid slot stores nothing, leaves that slot unchanged and sets the port's `ovf_o` bit.
- R7: Register address layout is {port, index, word}, with word 0 selecting the low word and word 1 the high word. The high word returns the stamp byte in bits [7:0], the port's overflow flag in bit 30 and the slot's valid bit in bit 31, with the other bits zero. `reg_rdata_o` shows the addressed word one cycle after `reg_rd_i`, taken from the state before that edge, and otherwise holds its value.
- R8: Writing zero to a low word zeroes the low word and leaves the valid bit unchanged. Writing zero to a high word zeroes the stamp byte, clears the valid bit and clears the overflow flag of that port.
- R9: Writing any nonzero value to either word has no effect.
- R10: When a requested transmit event and a receive event hit the same port in the same cycle, the transmit event is judged first. The receive event then takes the lowest free slot other than the one the transmit event took. Both stamps are stored.
- R11: When a zero write to a slot's high word and an accepted transmit capture to the same slot fall in the same cycle, the capture wins: the slot ends valid with the new stamp and no overflow is raised. When an overflow set and an overflow clear hit the same port in one cycle, the set wins. Receive slot search uses the valid bits from before the edge.
- R12: After reset every slot is invalid with zero contents, `ovf_o` is zero, `reg_rdata_o` is zero and `local_time_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_time_i | input | 64 | Lower 64 bits of the global source time |
| local_time_o | output | 64 | Local mirrored timer |
| rx_evt_i | input | 1 | Receive packet event |
| rx_port_i | input | 1 | Port of the receive event |
| tx_evt_i | input | 1 | Transmit packet event |
| tx_req_i | input | 1 | Timestamp requested for the transmit event |
| tx_port_i | input | 1 | Port of the transmit event |
| tx_idx_i | input | 2 | Slot named by the transmit event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register address {port, index, word} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| ovf_o | output | 2 | Sticky overflow flag per port |

## Verification
The sharpest collision is a software clear of a slot's high word landing in the same cycle as a requested transmit capture to that slot. A directed cycle drives both strobes on one edge. The slot is then read back, and it must be valid, hold the new stamp and leave the overflow flag untouched. A second directed cycle makes a receive drop on a full port coincide with a clear of that port, to show that the overflow set wins. The random phase keeps mixing captures, clears and reads on shared ports. Every read is compared against a bench model.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int TIME_W    = 64;
  localparam int WORD_W    = 32;
  localparam int VALID_POS = 31;
  localparam int OVF_POS   = 30;
endpackage

// File: rtl/ts_local_timer.sv
module ts_local_timer
  import ts_cap_pkg::*;
#(
  parameter int TS_W   = 40,
  parameter int TS_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] src_time_i,
  output logic [TIME_W-1:0] time_o,
  output logic [TS_W-1:0]   stamp_o
);
  logic [TIME_W-1:0] tmr_d, tmr_q;

  always_comb begin
    tmr_d = src_time_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign time_o  = tmr_q;
  assign stamp_o = tmr_q[TS_LSB +: TS_W];
endmodule

// File: rtl/ts_free_pick.sv
module ts_free_pick #(
  parameter int N_IDX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IDX-1:0] free_i,
  output logic             ok_o,
  output logic [((N_IDX > 1) ? $clog2(N_IDX) : 1)-1:0] idx_o
);
  localparam int IDX_W = (N_IDX > 1) ? $clog2(N_IDX) : 1;

  // lowest-numbered free slot wins
  always_comb begin
    ok_o  = 1'b0;
    idx_o = '0;
    for (int i = N_IDX - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        ok_o  = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  // R2: a granted slot is one the caller marked free
  a_r2_pick_is_free: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> free_i[idx_o]);
  // R3: no free slot, no grant
  a_r3_full_no_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (free_i == '0) |-> !ok_o);
endmodule

// File: rtl/ts_entry_store.sv
module ts_entry_store
  import ts_cap_pkg::*;
#(
  parameter int N_PORTS = 2,
  parameter int N_IDX   = 4,
  parameter int TS_W    = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [TS_W-1:0] stamp_i,
  input  logic rx_we_i,
  input  logic [((N_PORTS*N_IDX > 1) ? $clog2(N_PORTS*N_IDX) : 1)-1:0] rx_ent_i,
  input  logic tx_we_i,
  input  logic [((N_PORTS*N_IDX > 1) ? $clog2(N_PORTS*N_IDX) : 1)-1:0] tx_ent_i,
  input  logic clr_lo_i,
  input  logic clr_hi_i,
  input  logic [((N_PORTS*N_IDX > 1) ? $clog2(N_PORTS*N_IDX) : 1)-1:0] clr_ent_i,
  input  logic [N_PORTS-1:0] ovf_set_i,
  input  logic [N_PORTS-1:0] ovf_clr_i,
  input  logic rd_en_i,
  input  logic rd_hi_i,
  input  logic [((N_PORTS*N_IDX > 1) ? $clog2(N_PORTS*N_IDX) : 1)-1:0] rd_ent_i,
  input  logic [((N_PORTS > 1) ? $clog2(N_PORTS) : 1)-1:0] rd_port_i,
  output logic [N_PORTS*N_IDX-1:0] vld_o,
  output logic [N_PORTS-1:0] ovf_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int N_ENT = N_PORTS * N_IDX;
  localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int HI_W  = TS_W - WORD_W;

  logic [WORD_W-1:0] lo_q [N_ENT];
  logic [WORD_W-1:0] lo_d [N_ENT];
  logic [HI_W-1:0]   hi_q [N_ENT];
  logic [HI_W-1:0]   hi_d [N_ENT];
  logic [N_ENT-1:0]  vld_d, vld_q;
  logic [N_PORTS-1:0] ovf_d, ovf_q;
  logic [WORD_W-1:0] rdata_d, rdata_q;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    vld_d = vld_q;
    for (int e = 0; e < N_ENT; e++) begin
      // clear first, capture afterwards so a capture wins (R11)
      if (clr_lo_i && clr_ent_i == ENT_W'(e)) lo_d[e] = '0;
      if (clr_hi_i && clr_ent_i == ENT_W'(e)) begin
        hi_d[e]  = '0;
        vld_d[e] = 1'b0;
      end
      if ((tx_we_i && tx_ent_i == ENT_W'(e)) || (rx_we_i && rx_ent_i == ENT_W'(e))) begin
        lo_d[e]  = stamp_i[WORD_W-1:0];
        hi_d[e]  = stamp_i[TS_W-1:WORD_W];
        vld_d[e] = 1'b1;
      end
    end
    ovf_d = (ovf_q & ~ovf_clr_i) | ovf_set_i;
    rdata_d = '0;
    if (rd_hi_i) begin
      rdata_d[HI_W-1:0] = hi_q[rd_ent_i];
      rdata_d[OVF_POS]   = ovf_q[rd_port_i];
      rdata_d[VALID_POS] = vld_q[rd_ent_i];
    end else begin
      rdata_d = lo_q[rd_ent_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) begin
        lo_q[e] <= '0;
        hi_q[e] <= '0;
      end
      vld_q   <= '0;
      ovf_q   <= '0;
      rdata_q <= '0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      vld_q <= vld_d;
      ovf_q <= ovf_d;
      if (rd_en_i) rdata_q <= rdata_d;
    end
  end

  assign vld_o   = vld_q;
  assign ovf_o   = ovf_q;
  assign rdata_o = rdata_q;

  // R10: receive and transmit never land on one slot in one cycle
  a_r10_no_double_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_we_i && tx_we_i) |-> (rx_ent_i != tx_ent_i));

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent_chk
    // R2: a slot only becomes valid through a capture
    a_r2_valid_only_by_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!vld_q[g] && !(rx_we_i && rx_ent_i == ENT_W'(g)) && !(tx_we_i && tx_ent_i == ENT_W'(g)))
      |=> !vld_q[g]);
    // R8: a zero write to the high word frees the slot unless a capture hits it
    a_r8_clear_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hi_i && clr_ent_i == ENT_W'(g) && !(rx_we_i && rx_ent_i == ENT_W'(g))
       && !(tx_we_i && tx_ent_i == ENT_W'(g))) |=> !vld_q[g]);
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port_chk
    // R3: overflow flag is sticky until cleared
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[p] && !ovf_clr_i[p]) |=> ovf_q[p]);
  end
endmodule

// File: rtl/ts_capture_mem.sv
module ts_capture_mem
  import ts_cap_pkg::*;
#(
  parameter int N_PORTS = 2,
  parameter int N_IDX   = 4,
  parameter int TS_W    = 40,
  parameter int TS_LSB  = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [63:0] src_time_i,
  output logic [63:0] local_time_o,
  input  logic rx_evt_i,
  input  logic [((N_PORTS > 1) ? $clog2(N_PORTS) : 1)-1:0] rx_port_i,
  input  logic tx_evt_i,
  input  logic tx_req_i,
  input  logic [((N_PORTS > 1) ? $clog2(N_PORTS) : 1)-1:0] tx_port_i,
  input  logic [((N_IDX > 1) ? $clog2(N_IDX) : 1)-1:0] tx_idx_i,
  input  logic reg_wr_i,
  input  logic reg_rd_i,
  input  logic [((N_PORTS > 1) ? $clog2(N_PORTS) : 1) + ((N_IDX > 1) ? $clog2(N_IDX) : 1):0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic [N_PORTS-1:0] ovf_o
);
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int IDX_W  = (N_IDX > 1) ? $clog2(N_IDX) : 1;
  localparam int ADDR_W = PORT_W + IDX_W + 1;
  localparam int N_ENT  = N_PORTS * N_IDX;
  localparam int ENT_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  function automatic logic [ENT_W-1:0] ent(input logic [PORT_W-1:0] p,
                                           input logic [IDX_W-1:0] i);
    return ENT_W'(int'(p) * N_IDX + int'(i));
  endfunction

  logic [TS_W-1:0]   stamp;
  logic [N_ENT-1:0]  vld;
  logic [PORT_W-1:0] a_port;
  logic [IDX_W-1:0]  a_idx;
  logic              a_hi;
  logic [ENT_W-1:0]  a_ent, tx_ent;
  logic              wr_zero, clr_lo, clr_hi;
  logic              tx_hit, tx_slot_free, tx_acc, tx_drop;
  logic [N_IDX-1:0]  rx_free;
  logic              rx_ok, rx_acc, rx_drop;
  logic [IDX_W-1:0]  rx_idx;
  logic [N_PORTS-1:0] ovf_set, ovf_clr;

  ts_local_timer #(.TS_W(TS_W), .TS_LSB(TS_LSB)) timer_i (
    .clk(clk), .rst_n(rst_n), .src_time_i(src_time_i),
    .time_o(local_time_o), .stamp_o(stamp)
  );

  // register address {port, index, word}
  assign a_hi   = reg_addr_i[0];
  assign a_idx  = reg_addr_i[IDX_W:1];
  assign a_port = reg_addr_i[ADDR_W-1:IDX_W+1];
  assign a_ent  = ent(a_port, a_idx);

  assign wr_zero = reg_wr_i && (reg_wdata_i == '0);
  assign clr_lo  = wr_zero && !a_hi;
  assign clr_hi  = wr_zero && a_hi;

  // transmit: only on request, only into a free (or freed this cycle) slot
  assign tx_ent       = ent(tx_port_i, tx_idx_i);
  assign tx_hit       = tx_evt_i && tx_req_i;
  assign tx_slot_free = !vld[tx_ent] || (clr_hi && (a_ent == tx_ent));
  assign tx_acc       = tx_hit && tx_slot_free;
  assign tx_drop      = tx_hit && !tx_slot_free;

  // receive: search free slots of the port, skipping the transmit target
  for (genvar i = 0; i < N_IDX; i++) begin : g_free
    assign rx_free[i] = !vld[ent(rx_port_i, IDX_W'(i))] &&
                        !(tx_acc && (tx_port_i == rx_port_i) && (tx_idx_i == IDX_W'(i)));
  end

  ts_free_pick #(.N_IDX(N_IDX)) pick_i (
    .clk(clk), .rst_n(rst_n), .free_i(rx_free), .ok_o(rx_ok), .idx_o(rx_idx)
  );

  assign rx_acc  = rx_evt_i && rx_ok;
  assign rx_drop = rx_evt_i && !rx_ok;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_ovf
    assign ovf_set[p] = (rx_drop && (rx_port_i == PORT_W'(p))) ||
                        (tx_drop && (tx_port_i == PORT_W'(p)));
    assign ovf_clr[p] = clr_hi && (a_port == PORT_W'(p));
  end

  ts_entry_store #(.N_PORTS(N_PORTS), .N_IDX(N_IDX), .TS_W(TS_W)) store_i (
    .clk(clk), .rst_n(rst_n), .stamp_i(stamp),
    .rx_we_i(rx_acc), .rx_ent_i(ent(rx_port_i, rx_idx)),
    .tx_we_i(tx_acc), .tx_ent_i(tx_ent),
    .clr_lo_i(clr_lo), .clr_hi_i(clr_hi), .clr_ent_i(a_ent),
    .ovf_set_i(ovf_set), .ovf_clr_i(ovf_clr),
    .rd_en_i(reg_rd_i), .rd_hi_i(a_hi), .rd_ent_i(a_ent), .rd_port_i(a_port),
    .vld_o(vld), .ovf_o(ovf_o), .rdata_o(reg_rdata_o)
  );

  // R6: a requested transmit to an occupied slot raises the port flag
  a_r6_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt_i && tx_req_i && vld[tx_ent] && !(clr_hi && a_ent == tx_ent)
     && !(clr_hi && a_port == tx_port_i)) |=> ovf_o[$past(tx_port_i)]);
endmodule

// File: tb/ts_capture_mem_tb_top.sv
module ts_capture_mem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [63:0] src_time;
  logic [63:0] local_time;
  logic rx_evt, tx_evt, tx_req, reg_wr, reg_rd;
  logic rx_port, tx_port;
  logic [1:0] tx_idx;
  logic [3:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [1:0] ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] m_lo [NP*NI];
  logic [7:0]  m_hi [NP*NI];
  bit          m_vld [NP*NI];
  bit          m_ovf [NP];
  logic [63:0] m_tmr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_capture_mem dut_i (
    .clk(clk), .rst_n(rst_n), .src_time_i(src_time), .local_time_o(local_time),
    .rx_evt_i(rx_evt), .rx_port_i(rx_port), .tx_evt_i(tx_evt), .tx_req_i(tx_req),
    .tx_port_i(tx_port), .tx_idx_i(tx_idx), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input int p, input int i, input bit hi);
    int e = p * NI + i;
    if (hi) return {m_vld[e], m_ovf[p], 22'b0, m_hi[e]};
    return m_lo[e];
  endfunction

  // model step from requirements, using pre-edge state
  task automatic model_update();
    int txe, we, found;
    bit clrhi, clrlo, tx_hit, tx_acc, tx_drop;
    logic [39:0] st;
    bit pv [NP*NI];
    int wp;
    st = m_tmr[63:24];
    for (int e = 0; e < NP*NI; e++) pv[e] = m_vld[e];
    txe = int'(tx_port) * NI + int'(tx_idx);
    wp = int'(reg_addr[3]);
    we = wp * NI + int'(reg_addr[2:1]);
    clrhi = reg_wr && reg_wdata == 0 && reg_addr[0];
    clrlo = reg_wr && reg_wdata == 0 && !reg_addr[0];
    tx_hit = tx_evt && tx_req;
    tx_acc = tx_hit && (!pv[txe] || (clrhi && we == txe));
    tx_drop = tx_hit && !tx_acc;
    found = -1;
    for (int i = 0; i < NI; i++) begin
      if (found < 0 && !pv[int'(rx_port)*NI+i] &&
          !(tx_acc && tx_port == rx_port && int'(tx_idx) == i)) found = i;
    end
    if (clrlo) m_lo[we] = 0;
    if (clrhi) begin m_hi[we] = 0; m_vld[we] = 0; m_ovf[wp] = 0; end
    if (tx_acc) begin m_lo[txe] = st[31:0]; m_hi[txe] = st[39:32]; m_vld[txe] = 1; end
    if (rx_evt && found >= 0) begin
      m_lo[int'(rx_port)*NI+found] = st[31:0];
      m_hi[int'(rx_port)*NI+found] = st[39:32];
      m_vld[int'(rx_port)*NI+found] = 1;
    end
    if (rx_evt && found < 0) m_ovf[int'(rx_port)] = 1;
    if (tx_drop) m_ovf[int'(tx_port)] = 1;
    m_tmr = src_time;
  endtask

  task automatic step(input string tag);
    bit do_rd;
    logic [31:0] er;
    do_rd = reg_rd;
    if (do_rd) er = mread(int'(reg_addr[3]), int'(reg_addr[2:1]), reg_addr[0]);
    @(posedge clk);
    model_update();
    @(negedge clk);
    if (do_rd) chk(tag, reg_rdata, er);
    chk("R3 R6 overflow flags", {30'b0, ovf}, {30'b0, m_ovf[1], m_ovf[0]});
    rx_evt = 0; tx_evt = 0; tx_req = 0; reg_wr = 0; reg_rd = 0;
    src_time = {$urandom, $urandom};
  endtask

  task automatic rd(input int p, input int i, input bit hi, input string tag);
    reg_rd = 1; reg_addr = {p[0], i[1:0], hi};
    step(tag);
  endtask

  task automatic wr(input int p, input int i, input bit hi, input logic [31:0] d);
    reg_wr = 1; reg_addr = {p[0], i[1:0], hi}; reg_wdata = d;
  endtask

  task automatic rx(input int p);
    rx_evt = 1; rx_port = p[0];
  endtask

  task automatic tx(input int p, input int i, input bit req);
    tx_evt = 1; tx_req = req; tx_port = p[0]; tx_idx = i[1:0];
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; rx_evt = 0; tx_evt = 0; tx_req = 0; reg_wr = 0; reg_rd = 0;
    rx_port = 0; tx_port = 0; tx_idx = 0; reg_addr = 0; reg_wdata = 0;
    src_time = 64'h0;
    for (int e = 0; e < NP*NI; e++) begin m_lo[e] = 0; m_hi[e] = 0; m_vld[e] = 0; end
    m_ovf[0] = 0; m_ovf[1] = 0; m_tmr = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 rdata after reset", reg_rdata, 32'h0);
    chk("R12 ovf after reset", {30'b0, ovf}, 32'h0);
    chk("R12 local time after reset", local_time[31:0], 32'h0);
    rst_n = 1;
    src_time = 64'h0123_4567_89AB_CDEF;
    step("R12 idle");
    // R1: mirror timer one cycle behind
    chk("R1 mirror low", local_time[31:0], 32'h89AB_CDEF);
    chk("R1 mirror high", local_time[63:32], 32'h0123_4567);
    rd(1, 3, 1, "R12 slot empty after reset");

    // R2 / R1 / R7: receive fills lowest slots
    rx(0); step("R2 rx a");
    rx(0); step("R2 rx b");
    rd(0, 0, 0, "R1 R7 low word slot0");
    rd(0, 0, 1, "R1 R7 high word slot0");
    rd(0, 1, 1, "R2 second slot valid");
    rd(0, 2, 1, "R2 third slot still free");

    // R4: no request, no capture
    tx(1, 2, 0); step("R4 tx without request");
    rd(1, 2, 1, "R4 slot untouched");
    // R5 / R6
    tx(1, 2, 1); step("R5 tx with request");
    rd(1, 2, 0, "R5 low word");
    rd(1, 2, 1, "R5 high word valid");
    tx(1, 2, 1); step("R6 tx to valid slot");
    rd(1, 2, 0, "R6 data unchanged");
    rd(1, 2, 1, "R6 overflow in high word");

    // R3: fill port 0 and overflow it
    rx(0); step("R2 rx c");
    rx(0); step("R2 rx d");
    rx(0); step("R3 rx on full port");
    rd(0, 3, 0, "R3 last slot unchanged");
    rd(0, 0, 1, "R3 overflow visible");

    // R9 / R8
    wr(0, 0, 1, 32'h1); step("R9 nonzero write high");
    wr(0, 0, 0, 32'hFFFF_FFFF); step("R9 nonzero write low");
    rd(0, 0, 0, "R9 low unchanged");
    rd(0, 0, 1, "R9 high unchanged");
    wr(0, 0, 0, 32'h0); step("R8 zero low");
    rd(0, 0, 0, "R8 low zeroed");
    rd(0, 0, 1, "R8 valid kept after low clear");
    wr(0, 0, 1, 32'h0); step("R8 zero high");
    rd(0, 0, 1, "R8 valid and overflow cleared");

    // R11: clear and capture same slot same cycle
    wr(1, 2, 1, 32'h0); tx(1, 2, 1); step("R11 clear with capture");
    rd(1, 2, 0, "R11 new stamp stored");
    rd(1, 2, 1, "R11 slot valid no overflow");
    // R11: overflow set and clear same port
    rx(0); step("R2 refill slot0");
    wr(0, 3, 1, 32'h0); rx(0); step("R11 drop with clear");
    rd(0, 3, 1, "R11 set wins, slot freed");

    // R10: rx and tx on same port same cycle
    for (int i = 0; i < NI; i++) begin wr(1, i, 1, 32'h0); step("R10 prep"); end
    tx(1, 0, 1); rx(1); step("R10 tx and rx together");
    for (int i = 0; i < NI; i++) rd(1, i, 1, "R10 port1 slot state");
    rd(1, 1, 0, "R10 rx stamp in slot1");

    // random phase
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 3 == 0) rx(int'($urandom % 2));
      if ($urandom % 3 == 0) tx(int'($urandom % 2), int'($urandom % 4), bit'($urandom % 4 != 0));
      if ($urandom % 4 == 0) wr(int'($urandom % 2), int'($urandom % 4), bit'($urandom % 2),
                                ($urandom % 4 == 0) ? $urandom : 32'h0);
      if ($urandom % 2 == 0) begin reg_rd = 1; reg_addr = 4'($urandom); end
      step("R7 R10 R11 random read");
    end
    for (int a = 0; a < 16; a++) rd(a / 8, (a / 2) % 4, bit'(a % 2), "R7 final sweep");
    finish_run();
  end
endmodule